// File: doc/BRIEF.md
# Address Complement Memory Test Sequencer

This block is a built-in self-test controller for a single-port, one-bit-wide synchronous RAM with one cycle of read latency. After a start pulse it clears the whole array to zero. It then runs two passes that visit addresses from both ends of the space toward the middle: lowest, highest, lowest+1, highest-1, and so on. Consecutive accesses therefore flip almost every address line, which is the point of the pattern. A final ascending sweep reads the array back. At every visit the old value is read and checked before the new value is written to the same location.

Each read is compared one cycle later, when the RAM returns the data. The first mismatch raises a sticky fail flag and captures the failing address. The run always continues to the end and finishes with a one-cycle done pulse. The number of locations may be any value up to two to the power of the address width, odd values included.

Top module: `ac_bist_top`

## Requirements
- R1: After an accepted start, the block first writes 0 (mem_we_o=1, mem_wdata_o=0) to every location in ascending order, one location per cycle.
- R2: In each inward pass the visit order is 0, DEPTH-1, 1, DEPTH-2, ... until every location has been visited once. For odd DEPTH the middle location is visited exactly once per pass.
- R3: Each visit is a read cycle (mem_we_o=0) immediately followed by a write cycle (mem_we_o=1) to the same address.
- R4: The first inward pass expects 0 on each read and writes 1. The second inward pass expects 1 and writes 0.
- R5: After the second pass, the block reads every location in ascending order, expecting 0. One further cycle with mem_we_o=0 completes the last compare.
- R6: The data returned on mem_rdata_i in the cycle after a read address is presented is compared with the expected value of that read.
- R7: The first mismatch sets fail_o and captures its address on fail_addr_o. Later mismatches leave fail_addr_o unchanged, and the run still completes to done.
- R8: fail_o and fail_addr_o keep their values after a run. Both are cleared to 0 only by the next accepted start.
- R9: done_o is high for exactly one cycle, in the cycle after the last compare. A mismatch on that last compare is already visible on fail_o and fail_addr_o in that cycle.
- R10: start_i is ignored while a run is in progress. The running sequence continues unchanged and produces a single done pulse.
- R11: After reset, done_o, fail_o, fail_addr_o and mem_we_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when the block is idle |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_addr_o | output | AW | Address of the first mismatch |
| mem_addr_o | output | AW | RAM address |
| mem_we_o | output | 1 | RAM write enable |
| mem_wdata_o | output | 1 | RAM write data |
| mem_rdata_i | input | 1 | RAM read data, valid one cycle after the address |

## Verification
Two functions fall in the same cycle: the compare of the last final-sweep read and the completion of the run. The bench provokes this by corrupting the top location only after the last write of the second pass. The expected result is that fail_o rises and fail_addr_o shows the top address in the very cycle done_o pulses, with fail_o still low one cycle earlier. The other coincidence is a compare landing in the write cycle of the same location. Stuck-at faults seeded by the bench's RAM model exercise it, and each must be reported at the exact address and pass predicted from the visit order.

// File: rtl/ac_bist_pkg.sv
package ac_bist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,   // background write sweep
    ST_PRD,     // inward pass, read cycle
    ST_PWR,     // inward pass, write cycle
    ST_FRD,     // final read sweep
    ST_DRAIN    // last compare
  } ac_state_e;
endpackage

// File: rtl/ac_bist_lin.sv
module ac_bist_lin #(
  parameter int AW    = 4,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          step_i,
  output logic [AW-1:0] cnt_o,
  output logic          last_o
);
  localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (init_i) cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST_A);

  // R1 / R5: a sweep never steps past the top location
  p_lin_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !init_i |-> cnt_q <= LAST_A);
endmodule

// File: rtl/ac_bist_ptr.sv
module ac_bist_ptr #(
  parameter int AW    = 4,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

  logic [AW-1:0] lo_q, hi_q;
  logic          hi_side_q;
  logic [AW:0]   lo_inc;

  assign lo_inc = {1'b0, lo_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q      <= '0;
      hi_q      <= LAST_A;
      hi_side_q <= 1'b0;
    end else if (init_i) begin
      lo_q      <= '0;
      hi_q      <= LAST_A;
      hi_side_q <= 1'b0;
    end else if (step_i) begin
      if (hi_side_q) begin
        lo_q      <= lo_q + 1'b1;
        hi_q      <= hi_q - 1'b1;
        hi_side_q <= 1'b0;
      end else begin
        hi_side_q <= 1'b1;
      end
    end
  end

  assign addr_o = hi_side_q ? hi_q : lo_q;
  // pass ends at the meeting point: middle (odd) or adjacent pair (even)
  assign last_o = hi_side_q ? (lo_inc == {1'b0, hi_q}) : (lo_q == hi_q);

  // R2: pointers never cross while a visit is in progress
  p_ptr_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !init_i |-> lo_q <= hi_q);
  // R2: after a low-side visit, the high side follows unless the pass ended
  p_ptr_alt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !init_i && !hi_side_q && !last_o |=> hi_side_q);
endmodule

// File: rtl/ac_bist_cmp.sv
module ac_bist_cmp #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          rd_i,
  input  logic          exp_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rdata_i,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o
);
  logic          chk_vld_q, chk_exp_q;
  logic [AW-1:0] chk_addr_q;
  logic          fail_q;
  logic [AW-1:0] fail_addr_q;
  logic          mis;

  // one-cycle RAM latency: hold read context until data arrives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_vld_q  <= 1'b0;
      chk_exp_q  <= 1'b0;
      chk_addr_q <= '0;
    end else begin
      chk_vld_q  <= rd_i;
      chk_exp_q  <= exp_i;
      chk_addr_q <= addr_i;
    end
  end

  assign mis = chk_vld_q && (rdata_i != chk_exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else if (clr_i) begin
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else if (mis) begin
      fail_q <= 1'b1;
      if (!fail_q) fail_addr_q <= chk_addr_q;
    end
  end

  assign fail_o      = fail_q;
  assign fail_addr_o = fail_addr_q;

  p_fail_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q && !clr_i |=> fail_q);
  p_first_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q && !clr_i |=> $stable(fail_addr_q));
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !fail_q && fail_addr_q == '0);
endmodule

// File: rtl/ac_bist_top.sv
module ac_bist_top
  import ac_bist_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic          mem_wdata_o,
  input  logic          mem_rdata_i
);
  ac_state_e     state_q, state_d;
  logic          pass_q, pass_d;
  logic          done_q;
  logic          start_acc;
  logic          lin_init, lin_step, lin_last;
  logic          ptr_init, ptr_step, ptr_last;
  logic [AW-1:0] lin_cnt, ptr_addr;
  logic          rd_en, rd_exp;

  assign start_acc = start_i && (state_q == ST_IDLE);

  ac_bist_lin #(.AW(AW), .DEPTH(DEPTH)) u_lin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (lin_init),
    .step_i (lin_step),
    .cnt_o  (lin_cnt),
    .last_o (lin_last)
  );

  ac_bist_ptr #(.AW(AW), .DEPTH(DEPTH)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (ptr_init),
    .step_i (ptr_step),
    .addr_o (ptr_addr),
    .last_o (ptr_last)
  );

  ac_bist_cmp #(.AW(AW)) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (start_acc),
    .rd_i        (rd_en),
    .exp_i       (rd_exp),
    .addr_i      (mem_addr_o),
    .rdata_i     (mem_rdata_i),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o)
  );

  always_comb begin
    state_d     = state_q;
    pass_d      = pass_q;
    lin_init    = 1'b0;
    lin_step    = 1'b0;
    ptr_init    = 1'b0;
    ptr_step    = 1'b0;
    rd_en       = 1'b0;
    rd_exp      = 1'b0;
    mem_addr_o  = '0;
    mem_we_o    = 1'b0;
    mem_wdata_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          lin_init = 1'b1;
          pass_d   = 1'b0;
          state_d  = ST_CLEAR;
        end
      end
      ST_CLEAR: begin
        mem_addr_o = lin_cnt;
        mem_we_o   = 1'b1;
        lin_step   = 1'b1;
        if (lin_last) begin
          ptr_init = 1'b1;
          state_d  = ST_PRD;
        end
      end
      ST_PRD: begin
        mem_addr_o = ptr_addr;
        rd_en      = 1'b1;
        rd_exp     = pass_q;
        state_d    = ST_PWR;
      end
      ST_PWR: begin
        mem_addr_o  = ptr_addr;
        mem_we_o    = 1'b1;
        mem_wdata_o = ~pass_q;
        ptr_step    = 1'b1;
        if (!ptr_last) begin
          state_d = ST_PRD;
        end else if (!pass_q) begin
          pass_d   = 1'b1;
          ptr_init = 1'b1;
          state_d  = ST_PRD;
        end else begin
          lin_init = 1'b1;
          state_d  = ST_FRD;
        end
      end
      ST_FRD: begin
        mem_addr_o = lin_cnt;
        rd_en      = 1'b1;
        lin_step   = 1'b1;
        if (lin_last) state_d = ST_DRAIN;
      end
      ST_DRAIN: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pass_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
      done_q  <= (state_q == ST_DRAIN);
    end
  end

  assign done_o = done_q;

  // R3: a write in a pass hits the address read in the previous cycle
  p_rw_same_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_PWR |-> (mem_addr_o == $past(mem_addr_o)) && !$past(mem_we_o));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && state_q != ST_IDLE && state_q != ST_CLEAR |=> state_q != ST_CLEAR);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> state_q == ST_IDLE);
endmodule

// File: tb/ac_bist_top_tb_top.sv
module ac_bist_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 3;
  localparam int D_OD = 7;
  localparam int D_EV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic arm = 1'b0;
  int   n_checks = 0;
  int   n_errors = 0;
  int   cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // odd-depth instance and its RAM
  logic          done0, fail0, we0, wd0, rd0;
  logic [AW-1:0] faddr0, a0;
  logic [7:0]    mem0 = 8'hff, s1 = '0, s0 = '0;
  logic          flip_en = 1'b0;
  logic [AW-1:0] flip_a = '0;
  int            wcnt0 = 0;

  ac_bist_top #(.AW(AW), .DEPTH(D_OD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(done0), .fail_o(fail0),
    .fail_addr_o(faddr0), .mem_addr_o(a0), .mem_we_o(we0), .mem_wdata_o(wd0),
    .mem_rdata_i(rd0));

  // even-depth instance and its RAM
  logic          done1, fail1, we1, wd1, rd1;
  logic [AW-1:0] faddr1, a1;
  logic [7:0]    mem1 = 8'hff;

  ac_bist_top #(.AW(AW), .DEPTH(D_EV)) dut_even_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(done1), .fail_o(fail1),
    .fail_addr_o(faddr1), .mem_addr_o(a1), .mem_we_o(we1), .mem_wdata_o(wd1),
    .mem_rdata_i(rd1));

  always @(posedge clk) begin
    if (arm) wcnt0 <= 0;
    else if (we0) wcnt0 <= wcnt0 + 1;
    if (we0) mem0[a0] <= wd0;
    rd0 <= ((mem0[a0] | s1[a0]) & ~s0[a0]) ^ (flip_en && wcnt0 == 3 * D_OD && a0 == flip_a);
    if (we1) mem1[a1] <= wd1;
    rd1 <= mem1[a1];
  end

  // trace logging
  logic [2:0]    lg_we [2][64];
  logic [2:0]    lg_wd [2][64];
  logic [AW-1:0] lg_ad [2][64];
  int   lg_n [2];
  logic rec [2];
  logic seen [2];
  logic fail_at [2];
  logic [AW-1:0] faddr_at [2];
  int   done_cnt [2];
  initial begin
    for (int i = 0; i < 2; i++) begin
      lg_n[i] = 0; rec[i] = 0; seen[i] = 0; done_cnt[i] = 0;
      fail_at[i] = 0; faddr_at[i] = '0;
    end
  end

  task automatic log_step(input int d, input logic dn, input logic fl, input logic [AW-1:0] fa,
                          input logic we, input logic wd, input logic [AW-1:0] ad);
    if (dn) done_cnt[d]++;
    if (arm) begin
      rec[d] = 1; seen[d] = 0; lg_n[d] = 0; done_cnt[d] = 0;
    end else if (rec[d]) begin
      if (dn) begin
        rec[d] = 0; seen[d] = 1; fail_at[d] = fl; faddr_at[d] = fa;
      end else if (lg_n[d] < 64) begin
        lg_we[d][lg_n[d]] = {2'b0, we};
        lg_wd[d][lg_n[d]] = {2'b0, wd};
        lg_ad[d][lg_n[d]] = ad;
        lg_n[d]++;
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    log_step(0, done0, fail0, faddr0, we0, wd0, a0);
    log_step(1, done1, fail1, faddr1, we1, wd1, a1);
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  // expected visit address for step k of an inward pass
  function automatic int visit(input int k, input int depth);
    return (k % 2 == 0) ? k / 2 : depth - 1 - k / 2;
  endfunction

  task automatic check_trace(input int d, input int depth);
    int e1 = 0, e2 = 0, e3 = 0, e4 = 0, e5 = 0;
    chk(lg_n[d] == 6 * depth + 1, "R5", "trace length", lg_n[d], 6 * depth + 1);
    if (lg_n[d] != 6 * depth + 1) return;
    for (int i = 0; i < depth; i++)
      if (lg_we[d][i] != 1 || lg_wd[d][i] != 0 || int'(lg_ad[d][i]) != i) e1++;
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < depth; k++) begin
        int b = depth + p * 2 * depth + 2 * k;
        if (int'(lg_ad[d][b]) != visit(k, depth)) e2++;
        if (lg_we[d][b] != 0 || lg_we[d][b+1] != 1 || lg_ad[d][b+1] != lg_ad[d][b]) e3++;
        if (int'(lg_wd[d][b+1]) != (p == 0 ? 1 : 0)) e4++;
      end
    for (int i = 0; i < depth; i++)
      if (lg_we[d][5*depth+i] != 0 || int'(lg_ad[d][5*depth+i]) != i) e5++;
    if (lg_we[d][6*depth] != 0) e5++;
    chk(e1 == 0, "R1", "clear sweep mismatches", e1, 0);
    chk(e2 == 0, "R2", "inward order mismatches", e2, 0);
    chk(e3 == 0, "R3", "read-then-write mismatches", e3, 0);
    chk(e4 == 0, "R4", "pass write data mismatches", e4, 0);
    chk(e5 == 0, "R5", "final sweep mismatches", e5, 0);
  endtask

  // start a run on both instances; optional stray start mid-run
  task automatic run(input int stray_at);
    @(negedge clk); start = 1; arm = 1;
    @(negedge clk); start = 0; arm = 0;
    chk(fail0 == 0 && faddr0 == 0, "R8", "fail cleared at start", fail0, 0);
    for (int i = 0; i < 200 && !(seen[0] && seen[1]); i++) begin
      if (i == stray_at) start = 1;
      @(negedge clk);
      start = 0;
    end
    repeat (3) @(negedge clk);
    chk(seen[0] && seen[1], "R9", "done observed", int'(seen[0] && seen[1]), 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(done0 == 0, "R11", "done after reset", done0, 0);
    chk(fail0 == 0 && faddr0 == 0, "R11", "fail after reset", fail0, 0);
    chk(we0 == 0 && we1 == 0, "R11", "we after reset", we0, 0);
  endtask

  task automatic t_clean();
    run(-1);
    check_trace(0, D_OD);
    check_trace(1, D_EV);
    chk(fail_at[0] == 0 && fail_at[1] == 0, "R9", "clean run fail", fail_at[0], 0);
    chk(done_cnt[0] == 1 && done_cnt[1] == 1, "R9", "done pulse count", done_cnt[0], 1);
    chk(mem0[6:0] == 0, "R5", "array zero after run", mem0[6:0], 0);
  endtask

  task automatic t_stuck_high();
    // addresses 1 and 5 read 1; order 0,6,1,5 so 1 fails first in pass 1 (R6, R7)
    s1 = 8'b0010_0010;
    run(-1);
    chk(fail_at[0] == 1, "R7", "fail with stuck-1", fail_at[0], 1);
    chk(faddr_at[0] == 1, "R7", "first failing address", faddr_at[0], 1);
    chk(lg_n[0] == 6 * D_OD + 1, "R7", "run completes after fail", lg_n[0], 6 * D_OD + 1);
    s1 = '0;
    repeat (6) @(negedge clk);
    chk(fail0 == 1 && faddr0 == 1, "R8", "fail held while idle", faddr0, 1);
  endtask

  task automatic t_stuck_low();
    // address 4 reads 0: pass 1 passes, pass 2 expects 1 (R4, R6)
    s0 = 8'b0001_0000;
    run(-1);
    chk(fail_at[0] == 1 && faddr_at[0] == 4, "R6", "stuck-0 address", faddr_at[0], 4);
    s0 = '0;
  endtask

  task automatic t_last_compare();
    // top location flips only during the final sweep: fail with done (R9)
    logic fail_before = 1'b1;
    flip_en = 1; flip_a = 3'd6;
    @(negedge clk); start = 1; arm = 1;
    @(negedge clk); start = 0; arm = 0;
    for (int i = 0; i < 200 && !done0; i++) begin
      fail_before = fail0;
      @(negedge clk);
    end
    chk(fail_before == 0, "R9", "fail low before done", fail_before, 0);
    chk(done0 == 1 && fail0 == 1, "R9", "fail with done", fail0, 1);
    chk(faddr0 == 6, "R9", "last compare address", faddr0, 6);
    repeat (10) @(negedge clk);
    flip_en = 0;
  endtask

  task automatic t_stray_start();
    run(12);
    check_trace(0, D_OD);
    chk(done_cnt[0] == 1, "R10", "single done with stray start", done_cnt[0], 1);
    chk(fail_at[0] == 0, "R10", "no fail with stray start", fail_at[0], 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_clean();
    t_stuck_high();
    t_clean();
    t_stuck_low();
    t_last_compare();
    t_stray_start();
    finish_sim();
  end
endmodule